// File: doc/BRIEF.md
# Link Retrain Sequencer

This block takes a serial link from its power-on speed up to its target generation without software taking part. On a start pulse it acts as a master on a simple register-access port. It first edits a one-time-writable capability register so that the link advertises the intended speed. It then reads the link status once to record the starting speed and width. After that it runs a fixed number of retrain passes. Each pass does a read-modify-write of the link control register to raise the retrain request, then polls the link status until the training-in-progress flag drops. At the end of every pass it records the negotiated speed and width.

The default configuration runs two passes. The first pass brings the link up again at its current speed, and the second settles it at the second generation. Each wait is guarded by a programmable cycle limit. If training is still in progress when that limit has run out, the sequencer raises an error flag and stops. The block is placed next to the link controller's register file and is started once per link bring-up.

Top module: `link_retrain_seq`

## Requirements
- R1: A one-cycle `start_i` in the idle state begins a sequence. While a sequence is running, a `start_i` pulse is ignored and does not restart or repeat any register access.
- R2: Before any control register write, the capability register (address 0) is read and written back once. In the written value, bits [3:0] are 2, bits [17:12] are 0, and every other bit keeps the value that was read.
- R3: Before the first retrain, the status register (address 2) is read once and stored as snapshot 0. The speed is taken from status bits [3:0] and the width from status bits [8:4].
- R4: Retraining is requested by a read-modify-write of the control register (address 1) that sets bit 5 and keeps every other bit as read.
- R5: After a retrain request, the status register is polled until bit 11 reads 0. No further step starts while bit 11 reads 1.
- R6: The retrain-and-wait pass runs exactly NUM_PASSES times (2 by default). After pass k, the speed and width read from the status register that cleared the wait are stored as snapshot k.
- R7: Each wait has a cycle counter that is cleared when the control write is issued. If a status read returns bit 11 = 1 after the counter has reached `tmo_limit_i`, `err_o` is set and no further register access is made. `done_o` stays 0, and later snapshots stay 0.
- R8: `done_o` is set when the last pass completes. It holds until the next accepted start, which clears `done_o`, `err_o` and all snapshots. `done_o` and `err_o` are never both 1.
- R9: A register request is completed in a cycle where `reg_req_o` and `reg_ack_i` are both 1. Until then, the address, write enable and write data are held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| tmo_limit_i | input | TMO_W | Wait limit in cycles for each pass |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | ADDR_W | 0 capability, 1 control, 2 status |
| reg_wdata_o | output | DATA_W | Write data |
| reg_ack_i | input | 1 | Access completes this cycle |
| reg_rdata_i | input | DATA_W | Read data, valid with ack |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Wait timed out |
| snap_speed_o | output | 4*(NUM_PASSES+1) | Speed snapshots, snapshot k at [4k+3:4k] |
| snap_width_o | output | 5*(NUM_PASSES+1) | Width snapshots, snapshot k at [5k+4:5k] |

## Verification
The bench surrounds the status fields with random noise bits. A design that extracts the speed or width from the wrong bits would then record values that do not match. It gives the capability and control registers random starting contents, so a plain write in place of a read-modify-write would destroy bits the bench checks. It forces timeouts in the first pass and in the second pass: a design that ignores the limit would hang, and one that keeps going after the timeout would issue an extra control write. It also sets a zero limit with training that finishes at once, which must still complete, and it pulses start mid-sequence, where a design that restarts would write the capability register twice.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CAP_RD,
      ST_CAP_WR,
      ST_SNAP_RD,
      ST_CTL_RD,
      ST_CTL_WR,
      ST_POLL
   } lrs_state_e;

   localparam int unsigned SPD_W   = 4;
   localparam int unsigned SPD_LSB = 0;
   localparam int unsigned WID_W   = 5;
   localparam int unsigned WID_LSB = 4;
endpackage

// File: rtl/lrs_wait_timer.sv
module lrs_wait_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expired_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear_i)
         cnt_q <= '0;
      else if (run_i && (cnt_q != {CNT_W{1'b1}}))
         cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/lrs_snap_store.sv
module lrs_snap_store #(
   parameter int unsigned NUM_SNAP = 3,
   parameter int unsigned IDX_W    = 2,
   parameter int unsigned SPD_W    = 4,
   parameter int unsigned WID_W    = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_i,
   input  logic                      load_i,
   input  logic [IDX_W-1:0]          idx_i,
   input  logic [SPD_W-1:0]          speed_i,
   input  logic [WID_W-1:0]          width_i,
   output logic [NUM_SNAP*SPD_W-1:0] speed_o,
   output logic [NUM_SNAP*WID_W-1:0] width_o
);
   for (genvar g = 0; g < NUM_SNAP; g++) begin : g_slot
      logic [SPD_W-1:0] spd_q;
      logic [WID_W-1:0] wid_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            spd_q <= '0;
            wid_q <= '0;
         end else if (clr_i) begin
            spd_q <= '0;
            wid_q <= '0;
         end else if (load_i && (idx_i == IDX_W'(g))) begin
            spd_q <= speed_i;
            wid_q <= width_i;
         end
      end

      assign speed_o[g*SPD_W +: SPD_W] = spd_q;
      assign width_o[g*WID_W +: WID_W] = wid_q;
   end
endmodule

// File: rtl/link_retrain_seq.sv
module link_retrain_seq
   import lrs_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned ADDR_CAP    = 0,
   parameter int unsigned ADDR_CTL    = 1,
   parameter int unsigned ADDR_STS    = 2,
   parameter int unsigned NUM_PASSES  = 2,
   parameter int unsigned TMO_W       = 16,
   parameter int unsigned RETRAIN_BIT = 5,
   parameter int unsigned TRAIN_BIT   = 11,
   parameter logic [DATA_W-1:0] CAP_SET = DATA_W'(32'h0000_0002),
   parameter logic [DATA_W-1:0] CAP_CLR = DATA_W'(32'h0003_F00F)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                start_i,
   input  logic [TMO_W-1:0]                    tmo_limit_i,
   output logic                                reg_req_o,
   output logic                                reg_we_o,
   output logic [ADDR_W-1:0]                   reg_addr_o,
   output logic [DATA_W-1:0]                   reg_wdata_o,
   input  logic                                reg_ack_i,
   input  logic [DATA_W-1:0]                   reg_rdata_i,
   output logic                                done_o,
   output logic                                err_o,
   output logic [(NUM_PASSES+1)*SPD_W-1:0]     snap_speed_o,
   output logic [(NUM_PASSES+1)*WID_W-1:0]     snap_width_o
);
   localparam int unsigned NUM_SNAP = NUM_PASSES + 1;
   localparam int unsigned IDX_W    = (NUM_SNAP > 1) ? $clog2(NUM_SNAP) : 1;
   localparam logic [DATA_W-1:0] RT_MASK = DATA_W'(1) << RETRAIN_BIT;

   initial begin
      assert (NUM_PASSES >= 1) else $error("NUM_PASSES must be at least 1");
      assert (TRAIN_BIT < DATA_W && RETRAIN_BIT < DATA_W) else $error("bit index out of range");
      assert (WID_LSB + WID_W <= DATA_W) else $error("status fields exceed DATA_W");
      assert (ADDR_STS < (1 << ADDR_W)) else $error("address does not fit ADDR_W");
      assert ((CAP_SET & ~CAP_CLR) == '0) else $error("CAP_SET outside CAP_CLR");
   end

   lrs_state_e        state_q;
   logic [IDX_W-1:0]  pass_q;
   logic [DATA_W-1:0] hold_q;
   logic              done_q, err_q;
   logic              xfer, train_busy, last_pass, tmo_hit;
   logic              snap_load, snap_clr;
   logic [IDX_W-1:0]  snap_idx;

   // Register port outputs follow the state
   always_comb begin
      reg_req_o   = (state_q != ST_IDLE);
      reg_we_o    = (state_q == ST_CAP_WR) || (state_q == ST_CTL_WR);
      reg_addr_o  = ADDR_W'(ADDR_STS);
      reg_wdata_o = '0;
      unique case (state_q)
         ST_CAP_RD: reg_addr_o = ADDR_W'(ADDR_CAP);
         ST_CAP_WR: begin
            reg_addr_o  = ADDR_W'(ADDR_CAP);
            reg_wdata_o = (hold_q & ~CAP_CLR) | CAP_SET;
         end
         ST_CTL_RD: reg_addr_o = ADDR_W'(ADDR_CTL);
         ST_CTL_WR: begin
            reg_addr_o  = ADDR_W'(ADDR_CTL);
            reg_wdata_o = hold_q | RT_MASK;
         end
         default: ;
      endcase
   end

   assign xfer       = reg_req_o && reg_ack_i;
   assign train_busy = reg_rdata_i[TRAIN_BIT];
   assign last_pass  = (pass_q == IDX_W'(NUM_PASSES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pass_q  <= '0;
         hold_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_CAP_RD;
               pass_q  <= '0;
               done_q  <= 1'b0;
               err_q   <= 1'b0;
            end
            ST_CAP_RD: if (xfer) begin
               hold_q  <= reg_rdata_i;
               state_q <= ST_CAP_WR;
            end
            ST_CAP_WR:  if (xfer) state_q <= ST_SNAP_RD;
            ST_SNAP_RD: if (xfer) state_q <= ST_CTL_RD;
            ST_CTL_RD: if (xfer) begin
               hold_q  <= reg_rdata_i;
               state_q <= ST_CTL_WR;
            end
            ST_CTL_WR:  if (xfer) state_q <= ST_POLL;
            ST_POLL: if (xfer) begin
               if (!train_busy) begin
                  if (last_pass) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     pass_q  <= pass_q + 1'b1;
                     state_q <= ST_CTL_RD;
                  end
               end else if (tmo_hit) begin
                  state_q <= ST_IDLE;
                  err_q   <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   lrs_wait_timer #(.CNT_W(TMO_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (state_q != ST_POLL),
      .run_i     (state_q == ST_POLL),
      .limit_i   (tmo_limit_i),
      .expired_o (tmo_hit)
   );

   assign snap_clr  = (state_q == ST_IDLE) && start_i;
   assign snap_load = xfer && ((state_q == ST_SNAP_RD) ||
                               ((state_q == ST_POLL) && !train_busy));
   assign snap_idx  = (state_q == ST_SNAP_RD) ? '0 : pass_q + 1'b1;

   lrs_snap_store #(
      .NUM_SNAP (NUM_SNAP),
      .IDX_W    (IDX_W),
      .SPD_W    (SPD_W),
      .WID_W    (WID_W)
   ) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (snap_clr),
      .load_i  (snap_load),
      .idx_i   (snap_idx),
      .speed_i (reg_rdata_i[SPD_LSB +: SPD_W]),
      .width_i (reg_rdata_i[WID_LSB +: WID_W]),
      .speed_o (snap_speed_o),
      .width_o (snap_width_o)
   );

   assign done_o = done_q;
   assign err_o  = err_q;
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned ADDR_CAP    = 0,
   parameter int unsigned ADDR_CTL    = 1,
   parameter int unsigned RETRAIN_BIT = 5,
   parameter logic [DATA_W-1:0] CAP_SET = DATA_W'(32'h2),
   parameter logic [DATA_W-1:0] CAP_CLR = DATA_W'(32'h3F00F)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_req_o,
   input logic              reg_we_o,
   input logic [ADDR_W-1:0] reg_addr_o,
   input logic [DATA_W-1:0] reg_wdata_o,
   input logic              reg_ack_i,
   input logic              done_o,
   input logic              err_o
);
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o) &&
                                  $stable(reg_we_o) && $stable(reg_wdata_o));

   p_cap_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req_o && reg_we_o && (reg_addr_o == ADDR_W'(ADDR_CAP)) |->
      ((reg_wdata_o & CAP_CLR) == CAP_SET));

   p_retrain_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req_o && reg_we_o && (reg_addr_o == ADDR_W'(ADDR_CTL)) |->
      reg_wdata_o[RETRAIN_BIT]);

   p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, err_o}));

   p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !reg_req_o);

   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !reg_req_o);
endmodule

bind link_retrain_seq lrs_checker #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .ADDR_CAP    (ADDR_CAP),
   .ADDR_CTL    (ADDR_CTL),
   .RETRAIN_BIT (RETRAIN_BIT),
   .CAP_SET     (CAP_SET),
   .CAP_CLR     (CAP_CLR)
) u_lrs_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_req_o   (reg_req_o),
   .reg_we_o    (reg_we_o),
   .reg_addr_o  (reg_addr_o),
   .reg_wdata_o (reg_wdata_o),
   .reg_ack_i   (reg_ack_i),
   .done_o      (done_o),
   .err_o       (err_o)
);

// File: tb/link_retrain_seq_bench.sv
module link_retrain_seq_bench;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] tmo_limit_i = 16'hFFFF;
   logic        reg_req_o, reg_we_o;
   logic [1:0]  reg_addr_o;
   logic [31:0] reg_wdata_o;
   logic        reg_ack_i;
   logic [31:0] reg_rdata_i;
   logic        done_o, err_o;
   logic [11:0] snap_speed_o;
   logic [14:0] snap_width_o;

   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   link_retrain_seq u_link_retrain_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tmo_limit_i(tmo_limit_i),
      .reg_req_o(reg_req_o), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
      .reg_wdata_o(reg_wdata_o), .reg_ack_i(reg_ack_i), .reg_rdata_i(reg_rdata_i),
      .done_o(done_o), .err_o(err_o),
      .snap_speed_o(snap_speed_o), .snap_width_o(snap_width_o)
   );

   // ---------------- register slave and link model ----------------
   logic        mdl_init = 1'b0;
   logic [31:0] ld_cap, ld_ctl;
   int          ld_len [2];
   logic [3:0]  spd_tab [3];
   logic [4:0]  wid_tab [3];

   logic [31:0] cap_reg, ctl_reg;
   logic [3:0]  noise;
   logic        training;
   int          tr_cnt, link_pass, lat_cnt;
   int          cap_wr_cnt, ctl_wr_cnt, cap_wr_before_ctl;
   logic        ack_q;
   logic [31:0] rd_q;

   assign reg_ack_i   = ack_q;
   assign reg_rdata_i = rd_q;

   always @(posedge clk) begin
      if (mdl_init) begin
         cap_reg <= ld_cap; ctl_reg <= ld_ctl; training <= 1'b0;
         tr_cnt <= 0; link_pass <= 0; lat_cnt <= 0; ack_q <= 1'b0; rd_q <= '0;
         cap_wr_cnt <= 0; ctl_wr_cnt <= 0; cap_wr_before_ctl <= 0;
         noise <= 4'($urandom);
      end else begin
         ack_q <= 1'b0;
         if (training) begin
            if (tr_cnt <= 1) begin
               training  <= 1'b0;
               link_pass <= link_pass + 1;
            end else
               tr_cnt <= tr_cnt - 1;
         end
         if (reg_req_o && !ack_q) begin
            if (lat_cnt == LAT) begin
               lat_cnt <= 0;
               ack_q   <= 1'b1;
               rd_q    <= '0;
               if (reg_we_o) begin
                  if (reg_addr_o == 2'd0) begin
                     cap_reg    <= reg_wdata_o;
                     cap_wr_cnt <= cap_wr_cnt + 1;
                     if (ctl_wr_cnt == 0) cap_wr_before_ctl <= 1;
                  end else if (reg_addr_o == 2'd1) begin
                     ctl_reg    <= reg_wdata_o & ~32'h20;
                     ctl_wr_cnt <= ctl_wr_cnt + 1;
                     if (reg_wdata_o[5] && link_pass < 2) begin
                        training <= 1'b1;
                        tr_cnt   <= ld_len[link_pass];
                     end
                  end
               end else begin
                  noise <= 4'($urandom);
                  case (reg_addr_o)
                     2'd0: rd_q <= cap_reg;
                     2'd1: rd_q <= ctl_reg;
                     default: rd_q <= {16'h0, noise, training, noise[1:0],
                                       wid_tab[link_pass], spd_tab[link_pass]};
                  endcase
               end
            end else
               lat_cnt <= lat_cnt + 1;
         end
      end
   end

   // ---------------- expected-value functions ----------------
   function automatic logic [31:0] exp_cap(input logic [31:0] init);
      return (init & ~32'h0003_F00F) | 32'h2;
   endfunction

   function automatic logic [11:0] exp_spd(input int n_snap);
      logic [11:0] v = '0;
      for (int i = 0; i < 3; i++) if (i < n_snap) v[i*4 +: 4] = spd_tab[i];
      return v;
   endfunction

   function automatic logic [14:0] exp_wid(input int n_snap);
      logic [14:0] v = '0;
      for (int i = 0; i < 3; i++) if (i < n_snap) v[i*5 +: 5] = wid_tab[i];
      return v;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // len0/len1: training length per pass; exp_passes: passes that finish
   task automatic run_case(input logic [31:0] cap0, input logic [31:0] ctl0,
                           input int len0, input int len1, input logic [15:0] lim,
                           input int exp_passes, input bit poke_start);
      bit hung = 1'b0;
      @(negedge clk);
      ld_cap = cap0; ld_ctl = ctl0 & ~32'h20; ld_len[0] = len0; ld_len[1] = len1;
      for (int i = 0; i < 3; i++) begin
         spd_tab[i] = 4'($urandom);
         wid_tab[i] = 5'($urandom);
      end
      tmo_limit_i = lim;
      mdl_init = 1'b1;
      @(negedge clk); mdl_init = 1'b0;
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      if (poke_start) begin
         repeat (7) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk); start_i = 1'b0;
      end
      for (int c = 0; ; c++) begin
         if (done_o || err_o) break;
         if (c > 30000) begin hung = 1'b1; break; end
         @(negedge clk);
      end
      check("R7 no hang", 32'(hung), 32'd0);
      check("R8 done", 32'(done_o), 32'(exp_passes == 2));
      check("R7 err", 32'(err_o), 32'(exp_passes < 2));
      check("R6 speed snapshots (R3 slot 0)", 32'(snap_speed_o), 32'(exp_spd(exp_passes + 1)));
      check("R6 width snapshots (R3 slot 0)", 32'(snap_width_o), 32'(exp_wid(exp_passes + 1)));
      check("R2 capability value", cap_reg, exp_cap(cap0));
      check("R2 cap written before control", 32'(cap_wr_before_ctl), 32'd1);
      check("R1 single capability write", 32'(cap_wr_cnt), 32'd1);
      check("R4 control bits kept", ctl_reg, ctl0 & ~32'h20);
      check("R6 R7 control write count", 32'(ctl_wr_cnt), 32'((exp_passes == 2) ? 2 : exp_passes + 1));
      check("R9 bus idle at end", 32'(reg_req_o), 32'd0);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R8 reset done", 32'(done_o), 32'd0);
      check("R8 reset err", 32'(err_o), 32'd0);
      check("R3 reset snapshots", {8'h0, snap_speed_o, 12'h0}, 32'h0);
      check("R9 reset request", 32'(reg_req_o), 32'd0);
      rst_n = 1'b1;

      // directed: all-ones registers, zero limit with instant training (R5, R7)
      run_case(32'hFFFF_FFFF, 32'hFFFF_FFDF, 1, 1, 16'd0, 2, 1'b0);
      // directed: timeout in pass 1 (R7)
      run_case(32'h1234_5678, 32'h0000_0F40, 4000, 5, 16'd25, 0, 1'b0);
      // directed: timeout in pass 2 (R7), earlier snapshots kept (R6)
      run_case(32'hA5A5_5A5A, 32'h0000_0003, 12, 4000, 16'd60, 1, 1'b0);
      // directed: start pulse while busy is ignored (R1), and start clears err (R8)
      run_case(32'h0F0F_F0F0, 32'h0000_8001, 30, 40, 16'hFFFF, 2, 1'b1);
      // long training that stays within the limit (R5)
      run_case(32'h0, 32'h0, 150, 200, 16'd260, 2, 1'b0);
      // constrained random
      for (int k = 0; k < 10; k++) begin
         run_case($urandom, $urandom, 2 + int'($urandom % 60), 2 + int'($urandom % 60),
                  16'd200, 2, 1'b0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R1: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule